// File: doc/BRIEF.md
# GPIO Output Latch with Set/Clear/Toggle

This block is the output stage of a 32-pin general-purpose I/O port that sits behind a simple register bus. It holds one output latch bit and one direction bit for each pin. It also samples the pad inputs through a synchronizer so that software can read them. Pin *k* maps to bit *k* of every register, so bit 0 is the lowest pin and bit 31 is the highest.

The latch can be changed in four ways:

- A store to the data register replaces all 32 bits at once.
- A store to the set alias raises only the bits written as 1.
- A store to the clear alias lowers only the bits written as 1.
- A store to the toggle alias inverts only the bits written as 1.

The three aliases are write-only and always read as zero. The latch follows every write whatever the direction bits hold. The direction bits only gate the pad output enable, so software can stage a level on an input pin before turning it into an output.

The bus has one access per cycle, marked by `bus_sel`, with `bus_wr` choosing a write. Register offsets are byte addresses:

| Offset | Register | Access |
|---|---|---|
| 0x00 | Data | write replaces the latch; read returns the synchronized pads |
| 0x04 | Set alias | write only |
| 0x08 | Clear alias | write only |
| 0x0C | Toggle alias | write only |
| 0x10 | Direction (1 = output) | read and write |
| 0x14 | Latch readback | read only |

Any other address is unmapped.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset the latch and the direction register are all zero, so `pad_out` and `pad_oe` are zero and reads of offsets 0x10 and 0x14 return zero.
- R2: A write to offset 0x00 replaces all 32 latch bits with the write data; `pad_out` shows the new value in the cycle after the write edge.
- R3: A write to offset 0x04 sets to 1 every latch bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A write to offset 0x08 clears to 0 every latch bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R6: A read of offset 0x04, 0x08 or 0x0C returns zero.
- R7: A write to offset 0x10 loads the direction register, and `pad_oe` equals it bit for bit. `pad_out` always equals the latch, so latch updates take effect on pins whose direction bit is 0 (input) as well.
- R8: A read of offset 0x00 returns `pad_in` through a two-flop synchronizer. A pad change made just after edge 0 is returned by a read sampled at edge 3 or later; reads sampled at edges 1 and 2 still return the old value.
- R9: A read of offset 0x10 returns the direction register, and a read of offset 0x14 returns the latch. Offset 0x14 is read-only, so a write there changes nothing.
- R10: A write to any unmapped address, including a misaligned one such as 0x02 or 0x18, changes nothing, and a read from one returns zero.
- R11: Read data appears on `bus_rdata` in the cycle after the edge that samples the read, and `bus_rdata` is zero in any cycle that follows an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels (latch contents) |
| pad_oe | output | 32 | Pad output enables (direction register) |

## Verification
A wrong latch bit shows at `pad_out` in the first cycle after the write that caused it. A set, clear or toggle that leaks into the bits written as 0 therefore shows up at once, and a bench-side model of the latch catches it. A wrong direction bit shows at `pad_oe` in the same cycle. A decode error shows in one of three ways: a stray change on the pads after a write to an alias, readback or unmapped address; a non-zero read of an alias; or a read of the wrong register one cycle after the request. A synchronizer with the wrong depth returns the new pad value one read too early or too late in a run of back-to-back reads.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;

    // Register byte offsets on the bus
    localparam int OFS_DATA   = 'h00;
    localparam int OFS_SET    = 'h04;
    localparam int OFS_CLEAR  = 'h08;
    localparam int OFS_TOGGLE = 'h0C;
    localparam int OFS_DIR    = 'h10;
    localparam int OFS_LATCH  = 'h14;

    // Operation applied to the output latch in one cycle
    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLEAR,
        OP_TOGGLE
    } latch_op_e;

    // Source of the read data register
    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_PADS,
        RSEL_DIR,
        RSEL_LATCH
    } rd_sel_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_latch_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output latch_op_e         op,
    output logic              dir_we,
    output logic              rd_en,
    output rd_sel_e           rd_sel
);

    logic do_wr;
    logic do_rd;

    assign do_wr = bus_sel && bus_wr;
    assign do_rd = bus_sel && !bus_wr;
    assign rd_en = do_rd;

    // Write side: only one register can be targeted per cycle
    always_comb begin
        op     = OP_NONE;
        dir_we = 1'b0;
        if (do_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_DATA):   op     = OP_LOAD;
                ADDR_W'(OFS_SET):    op     = OP_SET;
                ADDR_W'(OFS_CLEAR):  op     = OP_CLEAR;
                ADDR_W'(OFS_TOGGLE): op     = OP_TOGGLE;
                ADDR_W'(OFS_DIR):    dir_we = 1'b1;
                default:             op     = OP_NONE;
            endcase
        end
    end

    // Read side: aliases and unmapped addresses read as zero
    always_comb begin
        rd_sel = RSEL_ZERO;
        if (do_rd) begin
            unique case (bus_addr)
                ADDR_W'(OFS_DATA):  rd_sel = RSEL_PADS;
                ADDR_W'(OFS_DIR):   rd_sel = RSEL_DIR;
                ADDR_W'(OFS_LATCH): rd_sel = RSEL_LATCH;
                default:            rd_sel = RSEL_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/gpio_latch_core.sv
module gpio_latch_core
    import gpio_latch_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  latch_op_e    op,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);

    logic [W-1:0] latch_d;

    // Bitwise update: bits written as 0 keep their value in the alias ops
    always_comb begin
        unique case (op)
            OP_LOAD:   latch_d = wdata;
            OP_SET:    latch_d = latch_q | wdata;
            OP_CLEAR:  latch_d = latch_q & ~wdata;
            OP_TOGGLE: latch_d = latch_q ^ wdata;
            default:   latch_d = latch_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            if (dir_we) begin
                dir_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
    import gpio_latch_pkg::*;
#(
    parameter int W           = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);

    latch_op_e    op;
    logic         dir_we;
    logic         rd_en;
    rd_sel_e      rd_sel;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pads_sync;
    logic [W-1:0] rd_mux;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .op       (op),
        .dir_we   (dir_we),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel)
    );

    gpio_latch_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .dir_we  (dir_we),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pads_sync)
    );

    always_comb begin
        unique case (rd_sel)
            RSEL_PADS:  rd_mux = pads_sync;
            RSEL_DIR:   rd_mux = dir_q;
            RSEL_LATCH: rd_mux = latch_q;
            default:    rd_mux = '0;
        endcase
    end

    // One cycle of read latency; zero when no read was sampled
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_latch_port_chk.sv
module gpio_latch_port_chk
    import gpio_latch_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe
);

    logic wr_any, rd_any;
    logic hit_data, hit_set, hit_clr, hit_tgl, hit_dir, hit_latch, hit_none;

    assign wr_any    = bus_sel && bus_wr;
    assign rd_any    = bus_sel && !bus_wr;
    assign hit_data  = bus_addr == ADDR_W'(OFS_DATA);
    assign hit_set   = bus_addr == ADDR_W'(OFS_SET);
    assign hit_clr   = bus_addr == ADDR_W'(OFS_CLEAR);
    assign hit_tgl   = bus_addr == ADDR_W'(OFS_TOGGLE);
    assign hit_dir   = bus_addr == ADDR_W'(OFS_DIR);
    assign hit_latch = bus_addr == ADDR_W'(OFS_LATCH);
    assign hit_none  = !(hit_data || hit_set || hit_clr || hit_tgl || hit_dir || hit_latch);

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_data) |=> pad_out == $past(bus_wdata)); // R2

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_set) |=> pad_out == ($past(pad_out) | $past(bus_wdata))); // R3

    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_clr) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata))); // R4

    AST_TOGGLE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_tgl) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata))); // R5

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (hit_set || hit_clr || hit_tgl)) |=> bus_rdata == '0); // R6

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_dir) |=> (pad_oe == $past(bus_wdata)) && $stable(pad_out)); // R7

    AST_LATCH_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_latch) |=> $stable(pad_out) && $stable(pad_oe)); // R9

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && hit_none) |=> $stable(pad_out) && $stable(pad_oe)); // R10

    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && hit_none) |=> bus_rdata == '0); // R10

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> bus_rdata == '0); // R11

endmodule

bind gpio_latch_port gpio_latch_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_latch_port_bench.sv
module gpio_latch_port_bench;

    localparam int W      = 32;
    localparam int ADDR_W = 5;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } rd_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic [W-1:0]      pad_in = '0;
    logic [W-1:0]      pad_out;
    logic [W-1:0]      pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    rd_item_t rd_q[$];
    logic [W-1:0] m_latch = '0;
    logic [W-1:0] m_dir   = '0;

    always #2.5 clk = ~clk;

    gpio_latch_port u_gpio_latch_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic bus_write(logic [ADDR_W-1:0] a, logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, logic [W-1:0] exp, string req);
        rd_item_t it;
        it.exp = exp;
        it.req = req;
        rd_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_pads(string req);
        check({req, " pad_out"}, pad_out, m_latch);
        check({req, " pad_oe"}, pad_oe, m_dir);
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge
    initial begin
        forever begin
            bit fire;
            @(posedge clk);
            fire = rst_n && bus_sel && !bus_wr;
            @(negedge clk);
            if (fire) begin
                if (rd_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
                end else begin
                    rd_item_t it;
                    it = rd_q.pop_front();
                    check(it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pads("R1");
        bus_read(5'h14, '0, "R1 latch readback");
        bus_read(5'h10, '0, "R1 dir readback");

        // R2 direct load
        m_latch = 32'hA5A5_0F0F;
        bus_write(5'h00, m_latch);
        check_pads("R2");
        bus_read(5'h14, m_latch, "R2 latch readback");

        // R3 set, including bit 31 and bit 0 already high
        m_latch = m_latch | 32'h8000_00F1;
        bus_write(5'h04, 32'h8000_00F1);
        check_pads("R3");

        // R4 clear
        m_latch = m_latch & ~32'h0100_0005;
        bus_write(5'h08, 32'h0100_0005);
        check_pads("R4");

        // R5 toggle, twice with overlapping masks
        m_latch = m_latch ^ 32'hFFFF_0001;
        bus_write(5'h0C, 32'hFFFF_0001);
        check_pads("R5");
        m_latch = m_latch ^ 32'h0000_0003;
        bus_write(5'h0C, 32'h0000_0003);
        check_pads("R5");

        // R6 alias reads are zero
        bus_read(5'h04, '0, "R6 set alias read");
        bus_read(5'h08, '0, "R6 clear alias read");
        bus_read(5'h0C, '0, "R6 toggle alias read");

        // R7 direction gates enable only; latch still moves on input pins
        m_dir = 32'h0000_FFFF;
        bus_write(5'h10, m_dir);
        check_pads("R7");
        m_latch = m_latch | 32'h00F0_0000;
        bus_write(5'h04, 32'h00F0_0000);
        check_pads("R7");
        m_latch = m_latch ^ 32'h000F_0000;
        bus_write(5'h0C, 32'h000F_0000);
        check_pads("R7");

        // R9 readbacks and read-only latch register
        bus_read(5'h10, m_dir, "R9 dir readback");
        bus_read(5'h14, m_latch, "R9 latch readback");
        bus_write(5'h14, 32'hFFFF_FFFF);
        check_pads("R9");

        // R10 unmapped and misaligned addresses
        bus_write(5'h18, 32'hFFFF_FFFF);
        check_pads("R10");
        bus_write(5'h02, 32'h0000_0000);
        check_pads("R10");
        bus_write(5'h1C, 32'h1234_5678);
        check_pads("R10");
        bus_read(5'h18, '0, "R10 unmapped read");
        bus_read(5'h06, '0, "R10 misaligned read");

        // R11 idle cycle leaves read data at zero
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, '0);

        // R8 two-flop synchronizer: old, old, then new
        pad_in = 32'h1234_5678;
        bus_read(5'h00, '0, "R8 pad read edge1");
        bus_read(5'h00, '0, "R8 pad read edge2");
        bus_read(5'h00, 32'h1234_5678, "R8 pad read edge3");
        pad_in = 32'hFEDC_BA98;
        repeat (3) @(negedge clk);
        bus_read(5'h00, 32'hFEDC_BA98, "R8 pad read settled");

        repeat (2) @(negedge clk);
        if (rd_q.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", rd_q.size());
        end
        finish_run();
    end

endmodule